// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This bridge sits on the path from a processor-side request bus to the memory bus. Two 32 MiB alias windows are carved out of the address space. Every 32-bit word inside a window stands for one bit of a paired real memory region. A read through a window fetches the data that holds that bit and returns the bit alone. A write through a window performs a locked read-modify-write on the real memory that forces just that bit to the value in bit 0 of the write data. All other addresses are forwarded to memory unchanged.

Both sides use a valid/ready request handshake. Each side has a single-cycle response strobe that carries read data and an error flag. The bridge holds one transaction at a time. It keeps its request-side ready low from the moment it accepts a request until the response leaves, so nothing else can reach memory between the read and write phases of a read-modify-write. A configuration input switches both windows off together, and the window addresses then pass through like any other address.

Top module: `bitband_bridge`

## Requirements
- R1: With `alias_en`=1, an address whose bits [31:25] equal 7'h11 (0x22000000–0x23FFFFFF) is an alias of the real region based at 0x20000000, and one whose bits [31:25] equal 7'h21 (0x42000000–0x43FFFFFF) is an alias of the region based at 0x40000000.
- R2: The real address of an alias access is the region base ORed with (address[24:0] >> 5), rounded down to a multiple of the access size. The memory access uses the same size code as the alias access (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R3: The bit index is address[6:2] masked with (8 × bytes − 1). Data on both buses is right-justified and little-endian, with byte k in bits [8k+7:8k], so the index names a data bit directly.
- R4: An alias read makes exactly one memory read and returns the selected bit in response bit 0, with bits [31:1] zero.
- R5: An alias write makes a memory read followed by a memory write to the same address and size. The written data has the selected bit equal to write-data bit 0 and every other bit as read.
- R6: When the read phase of an alias access returns an error, the bridge flags an error on the response with zero data, and it issues no write phase.
- R7: An error on the write phase of an alias write is flagged on the response.
- R8: With `alias_en`=0, addresses inside the windows are forwarded unchanged, like non-alias addresses.
- R9: A non-alias access is forwarded with the same address, size, direction and write data. It makes one memory transaction, and its response data and error are returned unchanged.
- R10: `cpu_req_ready` is low from acceptance until the response cycle. No other memory transaction falls between the two phases of a read-modify-write. A memory request is held stable until it is accepted.
- R11: After reset the bridge is idle: `cpu_req_ready` is high, and no memory request or response is active.
- R12: Each accepted request yields exactly one response, lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alias_en | input | 1 | Enables both alias windows |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Bridge can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Request byte address |
| cpu_req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_req_wdata | input | 32 | Right-justified write data |
| cpu_rsp_valid | output | 1 | Response strobe |
| cpu_rsp_rdata | output | 32 | Response read data |
| cpu_rsp_err | output | 1 | Response error flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Memory request direction |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_size | output | 2 | Memory access size code |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_rdata | input | 32 | Memory read data |
| mem_rsp_err | input | 1 | Memory error flag |

## Verification
Two events can land in the same cycle. The bridge can issue the final response of a read-modify-write while a waiting request sees ready rise and is taken at the next edge. The bench provokes this by holding a second request valid during a whole alias write. It then judges from the memory-side trace that the read and write phases are adjacent and that the second request's transaction comes only after them, and it checks that the response strobe drops after one cycle. The table is walked a second time with the memory stalling every other cycle, so that request holding overlaps every phase.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int NUM_WIN  = 2;
  localparam int WIN_LOG2 = 25;

  localparam logic [NUM_WIN-1:0][31:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000};
  localparam logic [NUM_WIN-1:0][31:0] REAL_BASE  = {32'h4000_0000, 32'h2000_0000};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WB_REQ,
    ST_WB_WAIT
  } bb_state_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat_addr,
  output logic [BIT_W-1:0]  bitpos
);
  localparam int SHIFT = BIT_W;

  logic [NUM_WIN-1:0]             match;
  logic [NUM_WIN-1:0][ADDR_W-1:0] cand;
  logic [ADDR_W-1:0]              real_addr;
  logic [ADDR_W-1:0]              align_mask;
  logic [BIT_W-1:0]               raw_pos;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign match[w] = enable &&
      (addr[ADDR_W-1:WIN_LOG2] == ALIAS_BASE[w][ADDR_W-1:WIN_LOG2]);
    assign cand[w]  = REAL_BASE[w][ADDR_W-1:0] |
      ADDR_W'(addr[WIN_LOG2-1:0] >> SHIFT);
  end

  always_comb begin
    real_addr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (match[w]) real_addr = cand[w];
    end
  end

  assign raw_pos = addr[BIT_W+1:2];

  always_comb begin
    case (size)
      2'd0: begin
        align_mask = '1;
        bitpos     = raw_pos & BIT_W'(7);
      end
      2'd1: begin
        align_mask = ~ADDR_W'(1);
        bitpos     = raw_pos & BIT_W'(15);
      end
      default: begin
        align_mask = ~ADDR_W'(3);
        bitpos     = raw_pos;
      end
    endcase
  end

  assign hit       = |match;
  assign xlat_addr = real_addr & align_mask;

endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
  parameter int DATA_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic [DATA_W-1:0] src,
  input  logic [BIT_W-1:0]  bitpos,
  input  logic              set_val,
  output logic              bit_out,
  output logic [DATA_W-1:0] wb_data
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign wb_data[i] = (bitpos == BIT_W'(i)) ? set_val : src[i];
  end

  assign bit_out = src[bitpos];

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alias_en,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [1:0]        cpu_req_size,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              mem_rsp_err
);
  localparam int BIT_W = $clog2(DATA_W);

  bb_state_e         state_q, state_d;
  logic              write_q, alias_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0] wdata_q, hold_q;
  logic [BIT_W-1:0]  bitpos_q;
  logic              rsp_valid_q, rsp_err_q, rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;
  logic              accept, done, hold_en;

  logic              dec_hit;
  logic [ADDR_W-1:0] dec_addr;
  logic [BIT_W-1:0]  dec_bitpos;
  logic [DATA_W-1:0] bit_src, wb_data;
  logic              sel_bit;

  bb_decode #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_decode (
    .enable    (alias_en),
    .addr      (cpu_req_addr),
    .size      (cpu_req_size),
    .hit       (dec_hit),
    .xlat_addr (dec_addr),
    .bitpos    (dec_bitpos)
  );

  assign bit_src = (state_q == ST_WAIT) ? mem_rsp_rdata : hold_q;

  bb_bitops #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_bitops (
    .src     (bit_src),
    .bitpos  (bitpos_q),
    .set_val (wdata_q[0]),
    .bit_out (sel_bit),
    .wb_data (wb_data)
  );

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;

  // next state and response
  always_comb begin
    state_d     = state_q;
    done        = 1'b0;
    hold_en     = 1'b0;
    rsp_rdata_d = '0;
    rsp_err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!alias_q) begin
            done        = 1'b1;
            rsp_rdata_d = mem_rsp_rdata;
            rsp_err_d   = mem_rsp_err;
          end else if (mem_rsp_err) begin
            done      = 1'b1;
            rsp_err_d = 1'b1;
          end else if (!write_q) begin
            done        = 1'b1;
            rsp_rdata_d = DATA_W'(sel_bit);
          end else begin
            hold_en = 1'b1;
            state_d = ST_WB_REQ;
          end
          if (done) state_d = ST_IDLE;
        end
      end
      ST_WB_REQ: begin
        if (mem_req_ready) state_d = ST_WB_WAIT;
      end
      ST_WB_WAIT: begin
        if (mem_rsp_valid) begin
          done      = 1'b1;
          rsp_err_d = mem_rsp_err;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q  <= 1'b0;
      alias_q  <= 1'b0;
      size_q   <= '0;
      maddr_q  <= '0;
      wdata_q  <= '0;
      bitpos_q <= '0;
    end else if (accept) begin
      write_q  <= cpu_req_write;
      alias_q  <= dec_hit;
      size_q   <= cpu_req_size;
      maddr_q  <= dec_hit ? dec_addr : cpu_req_addr;
      wdata_q  <= cpu_req_wdata;
      bitpos_q <= dec_bitpos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= mem_rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else if (done) begin
      rsp_rdata_q <= rsp_rdata_d;
      rsp_err_q   <= rsp_err_d;
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_rdata_q;
  assign cpu_rsp_err   = rsp_err_q;

  assign mem_req_valid = (state_q == ST_REQ) || (state_q == ST_WB_REQ);
  assign mem_req_write = (state_q == ST_WB_REQ) ||
                         ((state_q == ST_REQ) && write_q && !alias_q);
  assign mem_req_addr  = maddr_q;
  assign mem_req_size  = size_q;
  assign mem_req_wdata = (state_q == ST_WB_REQ) ? wb_data : wdata_q;

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_ready,
  input logic        cpu_rsp_valid,
  input logic [31:0] cpu_rsp_rdata,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [1:0]  mem_req_size,
  input logic        alias_q
);
  logic [31:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_addr_q <= '0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_addr_q <= mem_req_addr;
  end

  assert_idle_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> cpu_req_ready && !mem_req_valid && !cpu_rsp_valid);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_size));

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  assert_alias_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && alias_q |->
      (mem_req_size == 2'd0) ||
      (mem_req_size == 2'd1 && !mem_req_addr[0]) ||
      (mem_req_addr[1:0] == 2'b00));

  assert_wb_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && alias_q |-> mem_req_addr == rd_addr_q);

  assert_single_bit_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && alias_q |-> cpu_rsp_rdata[31:1] == 31'd0);

endmodule

bind bitband_bridge bb_bridge_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_rdata (cpu_rsp_rdata),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .alias_q       (alias_q)
);

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alias_en = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [1:0]  cpu_req_size = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_err;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        mem_rsp_err = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bitband_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .alias_en(alias_en),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_size(cpu_req_size), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_err(cpu_rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err)
  );

  // memory model: real bytes, error regions, optional stalls, transaction trace
  logic [7:0]  mem [512];
  logic [7:0]  ref_mem [512];
  logic        stall_en = 1'b0;
  logic        tog = 1'b0;
  int          ops = 0;
  logic [31:0] tr_a [8];
  logic        tr_w [8];
  logic [1:0]  tr_s [8];

  assign mem_req_ready = !stall_en || tog;

  function automatic int idx(logic [31:0] a);
    return int'({a[30], a[7:0]});
  endfunction
  function automatic bit rd_err(logic [31:0] a);
    return a[15:12] == 4'hE;
  endfunction
  function automatic bit wr_err(logic [31:0] a);
    return a[15:12] == 4'hE || a[15:12] == 4'hD;
  endfunction
  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      logic [31:0] d;
      tr_a[ops % 8] = mem_req_addr;
      tr_w[ops % 8] = mem_req_write;
      tr_s[ops % 8] = mem_req_size;
      ops = ops + 1;
      d = '0;
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        mem_rsp_err <= wr_err(mem_req_addr);
        if (!wr_err(mem_req_addr))
          for (int k = 0; k < nbytes(mem_req_size); k++)
            mem[idx(mem_req_addr + k)] = mem_req_wdata[8*k +: 8];
      end else begin
        mem_rsp_err <= rd_err(mem_req_addr);
        if (!rd_err(mem_req_addr))
          for (int k = 0; k < nbytes(mem_req_size); k++)
            d[8*k +: 8] = mem[idx(mem_req_addr + k)];
      end
      mem_rsp_rdata <= d;
    end
  end

  // reference model from the requirements
  task automatic ref_do(input logic en, input logic wr, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic err, output int nops);
    int nb;
    logic [31:0] ra, d;
    int bp;
    bit is_alias;
    nb = nbytes(sz);
    is_alias = en && (a[31:25] == 7'h11 || a[31:25] == 7'h21);
    rd = '0; err = 1'b0; nops = 1; d = '0;
    if (is_alias) begin
      ra = (a[30] ? 32'h4000_0000 : 32'h2000_0000) | ({7'd0, a[24:0]} >> 5);
      ra = ra - (ra % nb);
      bp = int'((a >> 2) % (nb * 8));
      if (rd_err(ra)) begin
        err = 1'b1;
        return;
      end
      for (int k = 0; k < nb; k++) d[8*k +: 8] = ref_mem[idx(ra + k)];
      if (!wr) begin
        rd = {31'd0, d[bp]};
      end else begin
        nops = 2;
        d[bp] = wd[0];
        if (wr_err(ra)) err = 1'b1;
        else for (int k = 0; k < nb; k++) ref_mem[idx(ra + k)] = d[8*k +: 8];
      end
    end else if (wr) begin
      if (wr_err(a)) err = 1'b1;
      else for (int k = 0; k < nb; k++) ref_mem[idx(a + k)] = wd[8*k +: 8];
    end else begin
      if (rd_err(a)) err = 1'b1;
      else for (int k = 0; k < nb; k++) rd[8*k +: 8] = ref_mem[idx(a + k)];
    end
  endtask

  function automatic string tag_of(logic en, logic wr, logic [31:0] a, logic err);
    if (!en) return "R8";
    if (!(a[31:25] == 7'h11 || a[31:25] == 7'h21)) return "R9";
    if (err) return wr ? "R7" : "R6";
    return wr ? "R5" : "R4";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input logic en, input logic wr, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic err);
    @(negedge clk);
    alias_en = en; cpu_req_valid = 1'b1; cpu_req_write = wr;
    cpu_req_size = sz; cpu_req_addr = a; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_rdata;
    err = cpu_rsp_err;
  endtask

  task automatic run(input logic en, input logic wr, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] rd, erd;
    logic err, eerr;
    int n0, en_ops;
    string t;
    n0 = ops;
    do_acc(en, wr, sz, a, wd, rd, err);
    ref_do(en, wr, sz, a, wd, erd, eerr, en_ops);
    t = tag_of(en, wr, a, eerr);
    chk(t, rd, erd);
    chk(t, {31'd0, err}, {31'd0, eerr});
    chk({t, "/R10"}, ops - n0, en_ops);
  endtask

  // stimulus table: {alias_en, write, size, addr, wdata}
  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd2, 32'h2200_020C, 32'h0000_0000},
    {1'b1, 1'b1, 2'd2, 32'h2200_020C, 32'h0000_0001},
    {1'b1, 1'b0, 2'd2, 32'h2200_020C, 32'h0000_0000},
    {1'b1, 1'b1, 2'd0, 32'h2200_0404, 32'h0000_0000},
    {1'b1, 1'b0, 2'd0, 32'h2200_0404, 32'h0000_0000},
    {1'b1, 1'b0, 2'd1, 32'h4200_00F4, 32'h0000_0000},
    {1'b1, 1'b1, 2'd1, 32'h4200_00F4, 32'hFFFF_FFFE},
    {1'b1, 1'b0, 2'd2, 32'h4200_00F4, 32'h0000_0000},
    {1'b1, 1'b1, 2'd2, 32'h4200_007C, 32'h0000_0003},
    {1'b0, 1'b0, 2'd2, 32'h2200_0010, 32'h0000_0000},
    {1'b1, 1'b1, 2'd2, 32'h2000_0040, 32'hA5A5_1234},
    {1'b1, 1'b0, 2'd2, 32'h2000_0040, 32'h0000_0000},
    {1'b1, 1'b0, 2'd2, 32'h221C_0000, 32'h0000_0000},
    {1'b1, 1'b1, 2'd2, 32'h221A_0010, 32'h0000_0001},
    {1'b1, 1'b0, 2'd1, 32'h4000_E002, 32'h0000_0000},
    {1'b1, 1'b0, 2'd0, 32'h4200_1FFC, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, erd, rda;
    logic err, eerr, erra;
    int n0, dummy;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 29 + 7) & 255);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R11: idle while reset is held and after release
    chk("R11", {29'd0, cpu_req_ready, mem_req_valid, cpu_rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {29'd0, cpu_req_ready, mem_req_valid, cpu_rsp_valid}, 32'd4);

    for (int p = 0; p < 2; p++) begin
      stall_en = (p == 1);
      for (int v = 0; v < NV; v++)
        run(VEC[v][67], VEC[v][66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
    end
    stall_en = 1'b0;

    // R1/R2: second window, half-word: real 0x40000007 rounded to 0x40000006
    run(1'b1, 1'b0, 2'd1, 32'h4200_00F4, 32'd0);
    chk("R1", tr_a[(ops - 1) % 8], 32'h4000_0006);
    chk("R2", {30'd0, tr_s[(ops - 1) % 8]}, 32'd1);
    // R8: window address forwarded untouched when disabled
    run(1'b0, 1'b0, 2'd2, 32'h2200_020C, 32'd0);
    chk("R8", tr_a[(ops - 1) % 8], 32'h2200_020C);

    // R3: word write sets bit 13 (byte 1, bit 5) of word at 0x20000030
    run(1'b1, 1'b1, 2'd2, 32'h2200_0634, 32'd1);
    do_acc(1'b1, 1'b0, 2'd2, 32'h2000_0030, 32'd0, rd, err);
    ref_do(1'b1, 1'b0, 2'd2, 32'h2000_0030, 32'd0, erd, eerr, dummy);
    chk("R3", rd, 32'hCEB1_B477);
    // R3: byte access, index 14 masked to 6 within byte 0x31
    run(1'b1, 1'b1, 2'd0, 32'h2200_0638, 32'd1);
    do_acc(1'b1, 1'b0, 2'd2, 32'h2000_0030, 32'd0, rd, err);
    ref_do(1'b1, 1'b0, 2'd2, 32'h2000_0030, 32'd0, erd, eerr, dummy);
    chk("R3", rd, 32'hCEB1_F477);

    // R6: read error gives no write phase
    n0 = ops;
    do_acc(1'b1, 1'b1, 2'd2, 32'h221C_0004, 32'd1, rd, err);
    ref_do(1'b1, 1'b1, 2'd2, 32'h221C_0004, 32'd1, erd, eerr, dummy);
    chk("R6", {31'd0, err}, 32'd1);
    chk("R6", tr_w[(ops - 1) % 8] ? 32'd1 : 32'd0, 32'd0);
    chk("R6", ops - n0, 32'd1);

    // R10/R12: second request held valid during an alias write
    n0 = ops;
    @(negedge clk);
    alias_en = 1'b1; cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
    cpu_req_size = 2'd2; cpu_req_addr = 32'h2200_0800; cpu_req_wdata = 32'd0;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_write = 1'b0; cpu_req_addr = 32'h2000_0044;
    chk("R10", {31'd0, cpu_req_ready}, 32'd0);
    while (!cpu_rsp_valid) @(negedge clk);
    rda = cpu_rsp_rdata; erra = cpu_rsp_err;
    chk("R10", {31'd0, cpu_req_ready}, 32'd1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk("R12", {31'd0, cpu_rsp_valid}, 32'd0);
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_rdata; err = cpu_rsp_err;
    ref_do(1'b1, 1'b1, 2'd2, 32'h2200_0800, 32'd0, erd, eerr, dummy);
    chk("R5", {rda[30:0], erra}, {erd[30:0], eerr});
    ref_do(1'b1, 1'b0, 2'd2, 32'h2000_0044, 32'd0, erd, eerr, dummy);
    chk("R9", rd, erd);
    chk("R10", ops - n0, 32'd3);
    chk("R10", tr_a[n0 % 8], 32'h2000_0040);
    chk("R10", tr_a[(n0 + 1) % 8], 32'h2000_0040);
    chk("R10", {30'd0, tr_w[n0 % 8], tr_w[(n0 + 1) % 8]}, 32'd1);
    chk("R10", tr_a[(n0 + 2) % 8], 32'h2000_0044);
    @(negedge clk);
    chk("R12", {31'd0, cpu_rsp_valid}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule